// File: doc/BRIEF.md
# SPI Register Access Slave

This block gives an external host read and write access to a bank of 16-bit registers over a four-wire serial link. The link uses clock mode 0: the serial clock idles low, the receiver samples on the rising edge, and new data is launched on the falling edge. Bytes travel most significant bit first. An active-low select line frames each transaction. Its falling edge opens a transaction and its rising edge closes it.

The first byte of every transaction comes from the host and is a header. Bit 7 of the header gives the direction: 1 means read and 0 means write. Bit 6 is ignored. Bits 5:0 hold the register address. After the header, data moves in one direction only, high byte first.

- On a write, the payload arrives on MOSI and is committed to the register file as one strobe.
- On a read, the block fetches the register through a read strobe and shifts the value out on MISO.

All serial inputs pass through two-flop synchronisers into a core clock that runs at least four times faster than the serial clock. Edges of the serial clock and the select line are detected in the core clock domain. While the port is idle, MISO either floats or is driven low, selected by a configuration input.

Top module: `spi_regport`

## Requirements
- R1: After reset, `reg_we` and `reg_re` are low. With `miso_hiz_en` = 1, `miso_oe` is low.
- R2: Header bit 7 = 1 selects a read and 0 selects a write. Header bits 5:0 give the address presented on `reg_addr`. Header bit 6 has no effect on the address or the direction.
- R3: A write is committed after the second payload byte completes. This is one single-cycle `reg_we` pulse, with `reg_wdata` = {first payload byte, second payload byte}.
- R4: If the select line rises before the second write payload byte completes, no `reg_we` pulse occurs and the register keeps its old value.
- R5: A read gives exactly one single-cycle `reg_re` pulse. The 16-bit `reg_rdata` value then appears on MISO, most significant bit first. The first bit is valid before the first rising serial clock edge after the header.
- R6: While the select line is high, `miso_oe` equals the inverse of `miso_hiz_en`, and `miso` is 0.
- R7: While the select line is low during the header or a write payload, `miso_oe` is 1 and `miso` is 0.
- R8: Payload bytes beyond the second in a write transaction cause no further `reg_we` pulse and do not change the committed data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Active-low transaction select |
| miso_hiz_en | input | 1 | 1: MISO floats when idle; 0: MISO driven low when idle |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| reg_addr | output | 6 | Register address from the header |
| reg_wdata | output | 16 | Write data, valid with reg_we |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_re | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 16 | Read data, sampled in the cycle after reg_re's cycle |

## Verification
The aborted write is the situation that is hardest to bring about from the ports. The select line has to rise in the middle of the second payload byte, after the first byte and the header have already been accepted. The bench drives a transaction with a bit count that stops four bits into that byte. It then counts write strobes and reads the same address back to show that the old value survived. Extra-long writes and header bit 6 are exercised in the same way, each with a readback through the normal port.

// File: rtl/spi_regport_pkg.sv
// Package: shared constants for the SPI register access slave.
// Assumes an 8-bit header with the direction flag in its top bit.
package spi_regport_pkg;
    localparam int HDR_W     = 8;  // header byte width
    localparam int HDR_ADR_W = 6;  // address field width in header
    localparam int HDR_RD    = 7;  // position of read flag
endpackage

// File: rtl/spi_regport_sync.sv
// Module: multi-bit two-flop (or deeper) synchroniser with edge detection.
// Assumes each input bit is independent and slow relative to clk.
module spi_regport_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        // shift the raw input through the synchroniser chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
            else        chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end

    // remember the previous synchronised value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= q;
    end

    assign rise = q & ~prev;
    assign fall = ~q & prev;
endmodule

// File: rtl/spi_regport_frame.sv
// Module: transaction engine. Decodes the header, collects write payload,
// fetches and shifts out read data. Assumes synchronised, edge-detected inputs.
module spi_regport_frame
    import spi_regport_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_start,
    input  logic                 cs_end,
    input  logic                 sclk_rise,
    input  logic                 sclk_fall,
    input  logic                 mosi_s,
    output logic                 active,
    output logic                 rd_phase,
    output logic                 tx_bit,
    output logic [HDR_ADR_W-1:0] reg_addr,
    output logic [REG_W-1:0]     reg_wdata,
    output logic                 reg_we,
    output logic                 reg_re,
    input  logic [REG_W-1:0]     reg_rdata
);
    localparam int PAY_BYTES = REG_W / 8;
    localparam int BYTE_SAT  = PAY_BYTES + 1;
    localparam int BC_W      = $clog2(BYTE_SAT + 1);

    logic [2:0]         bit_cnt;
    logic [BC_W-1:0]    byte_cnt;
    logic [HDR_W-2:0]   rx;
    logic [REG_W-1:0]   wacc;
    logic [REG_W-1:0]   tx;
    logic               is_rd;

    // frame state, header decode and write commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            rd_phase  <= 1'b0;
            is_rd     <= 1'b0;
            bit_cnt   <= '0;
            byte_cnt  <= '0;
            rx        <= '0;
            wacc      <= '0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
            reg_re    <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            if (cs_start) begin
                active   <= 1'b1;
                rd_phase <= 1'b0;
                is_rd    <= 1'b0;
                bit_cnt  <= '0;
                byte_cnt <= '0;
            end else if (cs_end) begin
                active   <= 1'b0;
                rd_phase <= 1'b0;
            end else if (active) begin
                if (sclk_rise) begin
                    rx      <= {rx[HDR_W-3:0], mosi_s};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (byte_cnt != '0) wacc <= {wacc[REG_W-2:0], mosi_s};
                    if (bit_cnt == 3'd7) begin
                        if (byte_cnt != BC_W'(BYTE_SAT)) byte_cnt <= byte_cnt + 1'b1;
                        if (byte_cnt == '0) begin
                            is_rd    <= rx[HDR_RD-1];
                            reg_addr <= {rx[HDR_ADR_W-2:0], mosi_s};
                        end else if (byte_cnt == BC_W'(PAY_BYTES) && !is_rd) begin
                            reg_we    <= 1'b1;
                            reg_wdata <= {wacc[REG_W-2:0], mosi_s};
                        end
                    end
                end
                if (sclk_fall && is_rd && !rd_phase &&
                    byte_cnt == BC_W'(1) && bit_cnt == 3'd0) begin
                    rd_phase <= 1'b1;
                    reg_re   <= 1'b1;
                end
            end
        end
    end

    // read shift register: load after the strobe, shift on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n)                    tx <= '0;
        else if (reg_re)               tx <= reg_rdata;
        else if (sclk_fall && rd_phase) tx <= {tx[REG_W-2:0], 1'b0};
    end

    assign tx_bit = tx[REG_W-1];

    // R3: a write strobe lasts a single cycle
    assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    // R4: a write strobe only follows a fully received payload
    assert_we_after_payload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (byte_cnt == BC_W'(BYTE_SAT)));
    // R5: a read strobe only belongs to a read transaction and is single
    assert_re_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> (is_rd && rd_phase && !$past(reg_re)));
    // R2: a new transaction always starts from the header
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_start |=> (byte_cnt == '0 && !rd_phase));
endmodule

// File: rtl/spi_regport.sv
// Module: top of the SPI register access slave. Synchronises the serial pins,
// runs the transaction engine and drives MISO. Assumes clk >= 4x spi_sclk.
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int REG_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_sclk,
    input  logic                 spi_mosi,
    input  logic                 spi_cs_n,
    input  logic                 miso_hiz_en,
    output logic                 miso,
    output logic                 miso_oe,
    output logic [HDR_ADR_W-1:0] reg_addr,
    output logic [REG_W-1:0]     reg_wdata,
    output logic                 reg_we,
    output logic                 reg_re,
    input  logic [REG_W-1:0]     reg_rdata
);
    logic [2:0] s_q, s_rise, s_fall;
    logic       active, rd_phase, tx_bit;

    // bit 2: select (resets high), bit 1: mosi, bit 0: sclk
    spi_regport_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({spi_cs_n, spi_mosi, spi_sclk}),
        .q    (s_q),
        .rise (s_rise),
        .fall (s_fall)
    );

    spi_regport_frame #(.REG_W(REG_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_start (s_fall[2]),
        .cs_end   (s_rise[2]),
        .sclk_rise(s_rise[0]),
        .sclk_fall(s_fall[0]),
        .mosi_s   (s_q[1]),
        .active   (active),
        .rd_phase (rd_phase),
        .tx_bit   (tx_bit),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .reg_rdata(reg_rdata)
    );

    // MISO pad drive: read data in read phase, low otherwise, optional float when idle
    always_comb begin
        miso    = (active && rd_phase) ? tx_bit : 1'b0;
        miso_oe = active ? 1'b1 : !miso_hiz_en;
    end

    // R7: outside the read phase the driven MISO level is always low
    assert_quiet_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && !rd_phase) |-> !miso);
    // R6: with the float option set, an idle port never drives MISO
    assert_idle_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q[2] && !s_rise[2] && $past(s_q[2]) && miso_hiz_en) |-> !miso_oe);
endmodule

// File: tb/spi_regport_tb.sv
module spi_regport_tb;
    logic        clk = 0, rst_n = 0;
    logic        sclk = 0, mosi = 0, cs_n = 1, hiz_en = 1;
    logic        miso, miso_oe, reg_we, reg_re;
    logic [5:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic [15:0] mem [64];
    int          vec = 0, bad = 0, we_cnt = 0, re_cnt = 0;
    logic [5:0]  last_addr;
    logic [15:0] last_wdata;
    logic [47:0] rx_bits;
    int          quiet_bad;
    bit          done = 0;

    always #5 clk = ~clk;

    spi_regport u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
        .miso_hiz_en(hiz_en), .miso(miso), .miso_oe(miso_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    // register file model on the bench side
    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt++;
            last_addr  = reg_addr;
            last_wdata = reg_wdata;
        end
        if (reg_re) re_cnt++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one framed transaction; nbits sent MSB first from tx[47]
    task automatic frame(input logic [47:0] tx, input int nbits, input bit quiet);
        quiet_bad = 0;
        rx_bits = '0;
        cs_n = 0;
        #160;
        for (int i = 0; i < nbits; i++) begin
            mosi = tx[47-i];
            #70;
            rx_bits[47-i] = miso;
            if (quiet && (miso_oe !== 1'b1 || miso !== 1'b0)) quiet_bad++;
            #10 sclk = 1;
            #80 sclk = 0;
        end
        #80 cs_n = 1;
        #200;
    endtask

    task automatic t_reset();
        check(reg_we === 0 && reg_re === 0, "R1 strobes", {reg_we, reg_re}, 0);
        check(miso_oe === 0, "R1 miso_oe after reset", miso_oe, 0);
        check(we_cnt == 0, "R1 no write", we_cnt, 0);
    endtask

    task automatic t_write(input logic [5:0] a, input logic [15:0] d, input bit b6);
        int w0 = we_cnt;
        frame({1'b0, b6, a, d, 24'h0}, 24, 1);
        check(we_cnt == w0 + 1, "R3 one strobe", we_cnt - w0, 1);
        check(last_addr == a, "R2 write address", last_addr, a);
        check(last_wdata == d, "R3 write data", last_wdata, d);
        check(quiet_bad == 0, "R7 miso low in write", quiet_bad, 0);
    endtask

    task automatic t_read(input logic [5:0] a, input bit b6, input logic [15:0] exp);
        int r0 = re_cnt, w0 = we_cnt;
        frame({1'b1, b6, a, 40'h0}, 24, 0);
        check(re_cnt == r0 + 1, "R5 one read strobe", re_cnt - r0, 1);
        check(rx_bits[39:24] == exp, "R5 read data", rx_bits[39:24], exp);
        check(we_cnt == w0, "R2 read makes no write", we_cnt - w0, 0);
    endtask

    task automatic t_abort();
        int w0 = we_cnt;
        frame({2'b00, 6'h05, 16'hDEAD, 24'h0}, 20, 0);
        check(we_cnt == w0, "R4 aborted write", we_cnt - w0, 0);
        t_read(6'h05, 0, 16'h1234);
    endtask

    task automatic t_long();
        int w0 = we_cnt;
        frame({2'b00, 6'h21, 16'hBEEF, 16'h5555, 8'h0}, 40, 1);
        check(we_cnt == w0 + 1, "R8 single commit", we_cnt - w0, 1);
        check(last_wdata == 16'hBEEF, "R8 data unchanged", last_wdata, 16'hBEEF);
    endtask

    task automatic t_idle();
        hiz_en = 1;
        #50;
        check(miso_oe === 0, "R6 float when idle", miso_oe, 0);
        hiz_en = 0;
        #50;
        check(miso_oe === 1 && miso === 0, "R6 driven low when idle", {miso_oe, miso}, 2);
        hiz_en = 1;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        #100;
        t_reset();
        t_idle();
        t_write(6'h05, 16'h1234, 0);
        t_read(6'h05, 0, 16'h1234);
        t_write(6'h3F, 16'h8001, 1);   // R2: bit 6 set, address still 0x3F
        t_read(6'h3F, 1, 16'h8001);
        t_write(6'h00, 16'hA5C3, 0);
        t_read(6'h00, 0, 16'hA5C3);
        t_abort();
        t_long();
        t_read(6'h21, 0, 16'hBEEF);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            vec++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end
endmodule